// File: doc/BRIEF.md
# Timer Channel-Pair Compare Reference Generator

This block is the output-compare stage of one timer channel pair. A free-running up/down counter with a programmable wrap value drives two compare channels. Each channel turns the counter and its own compare value into a reference level, using a 4-bit mode code. The code selects one of these behaviours: a static level, an event on match, edge-aligned PWM, or a one-pulse window that a trigger opens. A third output, the combined reference, is derived from channel 1. It can also merge both channel references by OR, by AND, or by choosing one of them according to the count direction, which gives asymmetric center-aligned waveforms.

The counter has two states, `CNT_UP` and `CNT_DOWN`. While enabled it moves one step per clock in the direction held in that state. The direction input is sampled on each enabled clock and applies from the following step. An up count wraps from the wrap value (or above it) to 0. A down count wraps from 0 to the wrap value. Either wrap raises a one-cycle update pulse on the next cycle. Each channel holds a one-pulse machine with two states. `OP_WAIT` goes to `OP_PULSE` on a trigger. `OP_PULSE` stays in `OP_PULSE` on a trigger (retrigger). `OP_PULSE` goes back to `OP_WAIT` on an update pulse when no trigger arrives in the same cycle. In any mode that is not one-pulse, the machine is forced into `OP_WAIT`.

Every output is registered. Each reference reflects the counter value, the direction and the inputs seen at the clock edge that loads it.

Top module: `oc_ref_gen`

## Requirements
- R1: While reset is low, and on the first cycle after it, all three references and the update pulse are 0. The counter starts at 0 in the up state.
- R2: When enabled and counting up, the counter goes from a value >= the wrap value to 0. When counting down, it goes from 0 to the wrap value. Either wrap sets the update output high for exactly the next cycle, so the period is wrap value + 1 cycles.
- R3: Mode 6 (PWM 1) is active when counter < compare while counting up, and when counter <= compare while counting down. Mode 7 (PWM 2) is active when counter >= compare while counting up, and when counter > compare while counting down.
- R4: Mode 1 sets the reference on an enabled match (counter == compare). Mode 2 clears it on a match. Mode 3 inverts it on a match. Mode 0 and the unused codes 10 and 11 hold the reference.
- R5: Mode 4 drives the reference to 0 and mode 5 drives it to 1, from the next edge on.
- R6: Mode 8 (one-pulse 1) idles active while counting up and inactive while counting down. After a trigger it follows PWM 1 until the next update pulse, and then it returns to the idle level.
- R7: Mode 9 (one-pulse 2) idles inactive while counting up and active while counting down. After a trigger it follows PWM 2 while counting up and PWM 1 while counting down, until the next update pulse.
- R8: A trigger that arrives while a pulse is running, including in the cycle of the update pulse, keeps the pulse running through the next update.
- R9: In channel 1 mode 12 (combined 1), channel 1 acts as PWM 1 and the combined output is ref1 OR ref2. In mode 13 (combined 2), channel 1 acts as PWM 2 and the combined output is ref1 AND ref2.
- R10: In channel 1 modes 14 and 15 (asymmetric 1 and 2), channel 1 acts as PWM 1 or PWM 2 respectively. The combined output is taken from ref1 while counting up and from ref2 while counting down.
- R11: In every channel 1 mode from 0 to 11, the combined output equals ref1.
- R12: While the enable is low, the counter holds, no update pulse is raised and no match events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Counter enable |
| dir_down_i | input | 1 | 1 = count down, 0 = count up (applies from the next step) |
| arr_i | input | CNT_W | Counter wrap value |
| cmp1_i | input | CNT_W | Channel 1 compare value |
| cmp2_i | input | CNT_W | Channel 2 compare value |
| mode1_i | input | 4 | Channel 1 mode code |
| mode2_i | input | 4 | Channel 2 mode code |
| trig_i | input | 1 | Trigger for the one-pulse modes |
| ref1_o | output | 1 | Channel 1 reference |
| ref2_o | output | 1 | Channel 2 reference |
| comb_o | output | 1 | Combined channel 1 reference |
| upd_o | output | 1 | Update pulse, one cycle per wrap |

## Verification
The assertions check, on every cycle, the rules that relate state across one edge: both counter wraps with their update pulses, the hold while disabled, the force levels, and the function the combined output must take in the combined, asymmetric and plain modes. The bench's scenarios are needed for the sequences: the measured wrap period, the PWM duty cycles in both directions, the match events, and the one-pulse windows opened by triggers, with their retrigger and update timing. The bench compares these against its own cycle model.

// File: rtl/ocr_pkg.sv
package ocr_pkg;

    typedef enum logic [3:0] {
        OCM_FROZEN   = 4'd0,
        OCM_SET      = 4'd1,
        OCM_CLR      = 4'd2,
        OCM_TOGGLE   = 4'd3,
        OCM_FORCE_LO = 4'd4,
        OCM_FORCE_HI = 4'd5,
        OCM_PWM1     = 4'd6,
        OCM_PWM2     = 4'd7,
        OCM_OPM1     = 4'd8,
        OCM_OPM2     = 4'd9,
        OCM_CMB1     = 4'd12,
        OCM_CMB2     = 4'd13,
        OCM_ASY1     = 4'd14,
        OCM_ASY2     = 4'd15
    } ocm_e;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;

    typedef enum logic {
        OP_WAIT  = 1'b0,
        OP_PULSE = 1'b1
    } op_state_e;

endpackage

// File: rtl/ocr_counter.sv
module ocr_counter
    import ocr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             dir_down_i,
    input  logic [CNT_W-1:0] arr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cnt_up_o,
    output logic             upd_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    cnt_dir_e         dir_q, dir_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wrap;
    logic             upd_q;

    // wrap condition depends on the direction currently held
    always_comb begin
        unique case (dir_q)
            CNT_UP:   wrap = (cnt_q >= arr_i);
            CNT_DOWN: wrap = (cnt_q == CNT_ZERO);
            default:  wrap = 1'b0;
        endcase
    end

    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        if (en_i) begin
            dir_d = dir_down_i ? CNT_DOWN : CNT_UP;
            unique case (dir_q)
                CNT_UP:   cnt_d = wrap ? CNT_ZERO : cnt_q + 1'b1;
                CNT_DOWN: cnt_d = wrap ? arr_i    : cnt_q - 1'b1;
                default:  cnt_d = cnt_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dir_q <= CNT_UP;
            cnt_q <= CNT_ZERO;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= en_i && wrap;
        end
    end

    assign cnt_o    = cnt_q;
    assign cnt_up_o = (dir_q == CNT_UP);
    assign upd_o    = upd_q;

endmodule

// File: rtl/ocr_channel.sv
module ocr_channel
    import ocr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_up_i,
    input  logic             upd_i,
    input  logic             trig_i,
    input  logic [3:0]       mode_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             ref_d_o,
    output logic             ref_o
);

    ocm_e      mode;
    op_state_e st_q, st_d;
    logic      ref_q, ref_d;
    logic      pwm1, pwm2, match, is_opm;

    assign mode   = ocm_e'(mode_i);
    assign pwm1   = cnt_up_i ? (cnt_i <  cmp_i) : (cnt_i <= cmp_i);
    assign pwm2   = cnt_up_i ? (cnt_i >= cmp_i) : (cnt_i >  cmp_i);
    assign match  = en_i && (cnt_i == cmp_i);
    assign is_opm = (mode == OCM_OPM1) || (mode == OCM_OPM2);

    // one-pulse transitions: WAIT->PULSE on trigger, PULSE->WAIT on update
    always_comb begin
        st_d = st_q;
        if (!is_opm) begin
            st_d = OP_WAIT;
        end else begin
            unique case (st_q)
                OP_WAIT:  st_d = trig_i ? OP_PULSE : OP_WAIT;
                OP_PULSE: st_d = trig_i ? OP_PULSE : (upd_i ? OP_WAIT : OP_PULSE);
                default:  st_d = OP_WAIT;
            endcase
        end
    end

    always_comb begin
        case (mode)
            OCM_SET:      ref_d = match ? 1'b1 : ref_q;
            OCM_CLR:      ref_d = match ? 1'b0 : ref_q;
            OCM_TOGGLE:   ref_d = match ? ~ref_q : ref_q;
            OCM_FORCE_LO: ref_d = 1'b0;
            OCM_FORCE_HI: ref_d = 1'b1;
            OCM_PWM1,
            OCM_CMB1,
            OCM_ASY1:     ref_d = pwm1;
            OCM_PWM2,
            OCM_CMB2,
            OCM_ASY2:     ref_d = pwm2;
            OCM_OPM1:     ref_d = (st_d == OP_PULSE) ? pwm1 : cnt_up_i;
            OCM_OPM2:     ref_d = (st_d == OP_PULSE) ? (cnt_up_i ? pwm2 : pwm1)
                                                     : ~cnt_up_i;
            default:      ref_d = ref_q;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= OP_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ref_q <= 1'b0;
        end else begin
            ref_q <= ref_d;
        end
    end

    assign ref_d_o = ref_d;
    assign ref_o   = ref_q;

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
    import ocr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             dir_down_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic [CNT_W-1:0] cmp1_i,
    input  logic [CNT_W-1:0] cmp2_i,
    input  logic [3:0]       mode1_i,
    input  logic [3:0]       mode2_i,
    input  logic             trig_i,
    output logic             ref1_o,
    output logic             ref2_o,
    output logic             comb_o,
    output logic             upd_o
);

    localparam int NCH = 2;

    logic [CNT_W-1:0] cnt_q;
    logic             cnt_up;
    logic             upd_q;
    logic [NCH-1:0]   ref_d, ref_q;
    logic [3:0]       mode_v [NCH];
    logic [CNT_W-1:0] cmp_v  [NCH];
    logic             comb_d, comb_q;
    ocm_e             mode1;

    assign mode_v[0] = mode1_i;
    assign mode_v[1] = mode2_i;
    assign cmp_v[0]  = cmp1_i;
    assign cmp_v[1]  = cmp2_i;
    assign mode1     = ocm_e'(mode1_i);

    ocr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .dir_down_i (dir_down_i),
        .arr_i      (arr_i),
        .cnt_o      (cnt_q),
        .cnt_up_o   (cnt_up),
        .upd_o      (upd_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ocr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (en_i),
            .cnt_i    (cnt_q),
            .cnt_up_i (cnt_up),
            .upd_i    (upd_q),
            .trig_i   (trig_i),
            .mode_i   (mode_v[g]),
            .cmp_i    (cmp_v[g]),
            .ref_d_o  (ref_d[g]),
            .ref_o    (ref_q[g])
        );
    end

    // combined reference: merge rule picked by channel 1 mode
    always_comb begin
        case (mode1)
            OCM_CMB1: comb_d = ref_d[0] | ref_d[1];
            OCM_CMB2: comb_d = ref_d[0] & ref_d[1];
            OCM_ASY1,
            OCM_ASY2: comb_d = cnt_up ? ref_d[0] : ref_d[1];
            default:  comb_d = ref_d[0];
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            comb_q <= 1'b0;
        end else begin
            comb_q <= comb_d;
        end
    end

    assign ref1_o = ref_q[0];
    assign ref2_o = ref_q[1];
    assign comb_o = comb_q;
    assign upd_o  = upd_q;

endmodule

// File: rtl/ocr_chk.sv
module ocr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             en_i,
    input logic [CNT_W-1:0] arr_i,
    input logic [3:0]       mode1_i,
    input logic [CNT_W-1:0] cnt_q,
    input logic             cnt_up,
    input logic             ref1_o,
    input logic             ref2_o,
    input logic             comb_o,
    input logic             upd_o
);

    // R2
    up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && cnt_up && (cnt_q >= arr_i) |=> (cnt_q == '0) && upd_o);

    // R2
    down_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i && !cnt_up && (cnt_q == '0) |=> (cnt_q == $past(arr_i)) && upd_o);

    // R12
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(cnt_q) && !upd_o);

    // R5
    force_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode1_i == 4'd5 |=> ref1_o);

    // R5
    force_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode1_i == 4'd4 |=> !ref1_o);

    // R9
    comb_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode1_i == 4'd12 |=> comb_o == (ref1_o | ref2_o));

    // R9
    comb_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode1_i == 4'd13 |=> comb_o == (ref1_o & ref2_o));

    // R10
    asym_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode1_i[3:1] == 3'b111) && cnt_up |=> comb_o == ref1_o);

    // R10
    asym_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode1_i[3:1] == 3'b111) && !cnt_up |=> comb_o == ref2_o);

    // R11
    plain_comb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode1_i < 4'd12 |=> comb_o == ref1_o);

endmodule

bind oc_ref_gen ocr_chk #(.CNT_W(CNT_W)) u_ocr_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .arr_i   (arr_i),
    .mode1_i (mode1_i),
    .cnt_q   (cnt_q),
    .cnt_up  (cnt_up),
    .ref1_o  (ref1_o),
    .ref2_o  (ref2_o),
    .comb_o  (comb_o),
    .upd_o   (upd_o)
);

// File: tb/oc_ref_gen_test.sv
`timescale 1ns/1ps
module oc_ref_gen_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         dir_down = 1'b0;
    logic [W-1:0] arr = 16'd7;
    logic [W-1:0] cmp1 = '0;
    logic [W-1:0] cmp2 = '0;
    logic [3:0]   mode1 = 4'd0;
    logic [3:0]   mode2 = 4'd0;
    logic         trig = 1'b0;
    logic         ref1, ref2, comb, upd;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    oc_ref_gen #(.CNT_W(W)) uut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dir_down_i(dir_down),
        .arr_i(arr), .cmp1_i(cmp1), .cmp2_i(cmp2),
        .mode1_i(mode1), .mode2_i(mode2), .trig_i(trig),
        .ref1_o(ref1), .ref2_o(ref2), .comb_o(comb), .upd_o(upd)
    );

    // ---------------- behavioural expectation ----------------
    logic [W-1:0] m_cnt;
    logic         m_up, m_upd, m_r1, m_r2, m_comb, m_p1, m_p2;

    function automatic logic lvl_pwm(input bit second, input logic [W-1:0] c,
                                     input logic [W-1:0] k, input logic up);
        if (up) return second ? (c >= k) : (c < k);
        return second ? (c > k) : (c <= k);
    endfunction

    function automatic logic pulse_nxt(input logic [3:0] m, input logic run,
                                       input logic t, input logic u);
        if (m != 4'd8 && m != 4'd9) return 1'b0;
        if (t) return 1'b1;
        if (run && u) return 1'b0;
        return run;
    endfunction

    function automatic logic lvl_nxt(input logic [3:0] m, input logic cur,
                                     input logic run, input logic [W-1:0] c,
                                     input logic [W-1:0] k, input logic up,
                                     input logic e);
        logic hit;
        hit = e && (c == k);
        case (m)
            4'd1: return hit ? 1'b1 : cur;
            4'd2: return hit ? 1'b0 : cur;
            4'd3: return hit ? ~cur : cur;
            4'd4: return 1'b0;
            4'd5: return 1'b1;
            4'd6, 4'd12, 4'd14: return lvl_pwm(0, c, k, up);
            4'd7, 4'd13, 4'd15: return lvl_pwm(1, c, k, up);
            4'd8: return run ? lvl_pwm(0, c, k, up) : up;
            4'd9: return run ? lvl_pwm(!up ? 1'b0 : 1'b1, c, k, up) : !up;
            default: return cur;
        endcase
    endfunction

    always @(posedge clk) begin
        logic p1n, p2n, r1n, r2n, wrapping;
        if (!rst_n) begin
            m_cnt <= '0; m_up <= 1'b1; m_upd <= 1'b0;
            m_r1 <= 1'b0; m_r2 <= 1'b0; m_comb <= 1'b0;
            m_p1 <= 1'b0; m_p2 <= 1'b0;
        end else begin
            wrapping = m_up ? (m_cnt >= arr) : (m_cnt == 0);
            p1n = pulse_nxt(mode1, m_p1, trig, m_upd);
            p2n = pulse_nxt(mode2, m_p2, trig, m_upd);
            r1n = lvl_nxt(mode1, m_r1, p1n, m_cnt, cmp1, m_up, en);
            r2n = lvl_nxt(mode2, m_r2, p2n, m_cnt, cmp2, m_up, en);
            if (en) begin
                m_cnt <= wrapping ? (m_up ? '0 : arr) : (m_up ? m_cnt + 1'b1 : m_cnt - 1'b1);
                m_up  <= !dir_down;
            end
            m_upd <= en && wrapping;
            m_p1 <= p1n; m_p2 <= p2n;
            m_r1 <= r1n; m_r2 <= r2n;
            case (mode1)
                4'd12: m_comb <= r1n | r2n;
                4'd13: m_comb <= r1n & r2n;
                4'd14, 4'd15: m_comb <= m_up ? r1n : r2n;
                default: m_comb <= r1n;
            endcase
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check_bit(input string tag, input string what,
                             input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_bit(tag, "ref1", ref1, m_r1);
            check_bit(tag, "ref2", ref2, m_r2);
            check_bit(tag, "comb", comb, m_comb);
            check_bit(tag, "upd",  upd,  m_upd);
        end
    endtask

    task automatic fire(input string tag);
        trig = 1'b1;
        run(1, tag);
        trig = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R1", "ref1 in reset", ref1, 1'b0);
        check_bit("R1", "comb in reset", comb, 1'b0);
        check_bit("R1", "upd in reset", upd, 1'b0);
        rst_n = 1'b1;
        run(1, "R1");
        check_bit("R1", "ref2 after reset", ref2, 1'b0);
    endtask

    task automatic t_period;
        int gap;
        arr = 16'd4; mode1 = 4'd5; mode2 = 4'd4; en = 1'b1; dir_down = 1'b0;
        run(3, "R2");
        while (!upd) run(1, "R2");
        gap = 0;
        do begin run(1, "R2"); gap++; end while (!upd);
        n_chk++;
        if (gap != 5) begin n_err++; $display("FAIL R2 up period: actual=%0d expected=5", gap); end
        dir_down = 1'b1;
        run(8, "R2");
        while (!upd) run(1, "R2");
        gap = 0;
        do begin run(1, "R2"); gap++; end while (!upd);
        n_chk++;
        if (gap != 5) begin n_err++; $display("FAIL R2 down period: actual=%0d expected=5", gap); end
        dir_down = 1'b0;
        run(4, "R5");
        check_bit("R5", "forced high", ref1, 1'b1);
        check_bit("R5", "forced low", ref2, 1'b0);
    endtask

    task automatic t_pwm;
        arr = 16'd7; cmp1 = 16'd3; cmp2 = 16'd2; mode1 = 4'd6; mode2 = 4'd7;
        dir_down = 1'b0; run(20, "R3");
        dir_down = 1'b1; run(20, "R3");
        cmp1 = 16'd0; cmp2 = 16'd9; run(12, "R3");
        dir_down = 1'b0; run(12, "R3");
    endtask

    task automatic t_match;
        arr = 16'd5; cmp1 = 16'd2; cmp2 = 16'd4;
        mode1 = 4'd1; mode2 = 4'd3; run(14, "R4");
        mode1 = 4'd2; run(8, "R4");
        mode1 = 4'd5; run(2, "R4");
        mode1 = 4'd10; mode2 = 4'd11; run(10, "R4");
        check_bit("R4", "unused code holds", ref1, 1'b1);
        mode1 = 4'd0; run(8, "R4");
        check_bit("R4", "frozen holds", ref1, 1'b1);
    endtask

    task automatic t_opm;
        arr = 16'd7; cmp1 = 16'd3; cmp2 = 16'd5;
        mode1 = 4'd8; mode2 = 4'd9; dir_down = 1'b0;
        run(10, "R6"); fire("R6"); run(18, "R6");
        dir_down = 1'b1; run(10, "R7"); fire("R7"); run(18, "R7");
        dir_down = 1'b0; run(10, "R7"); fire("R7"); run(18, "R7");
    endtask

    task automatic t_retrig;
        arr = 16'd7; cmp1 = 16'd4; cmp2 = 16'd2; mode1 = 4'd8; mode2 = 4'd9;
        dir_down = 1'b0;
        while (!upd) run(1, "R8");
        run(2, "R8"); fire("R8");
        run(5, "R8"); fire("R8");
        while (!upd) run(1, "R8");
        fire("R8");
        run(20, "R8");
    endtask

    task automatic t_comb;
        arr = 16'd9; cmp1 = 16'd3; cmp2 = 16'd6; mode2 = 4'd7;
        mode1 = 4'd12; dir_down = 1'b0; run(15, "R9");
        dir_down = 1'b1; run(15, "R9");
        mode1 = 4'd13; run(15, "R9");
        dir_down = 1'b0; run(15, "R9");
        mode1 = 4'd14; mode2 = 4'd6; run(12, "R10");
        dir_down = 1'b1; run(12, "R10");
        mode1 = 4'd15; run(12, "R10");
        dir_down = 1'b0; run(12, "R10");
        mode1 = 4'd6; mode2 = 4'd7; run(15, "R11");
        mode1 = 4'd9; fire("R11"); run(15, "R11");
    endtask

    task automatic t_enable;
        logic held;
        arr = 16'd5; cmp1 = 16'd2; mode1 = 4'd3; mode2 = 4'd6; dir_down = 1'b0;
        run(7, "R12");
        en = 1'b0;
        run(1, "R12");
        held = ref1;
        run(12, "R12");
        check_bit("R12", "toggle frozen while disabled", ref1, held);
        check_bit("R12", "no update while disabled", upd, 1'b0);
        en = 1'b1;
        run(12, "R12");
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_period;
                t_pwm;
                t_match;
                t_opm;
                t_retrig;
                t_comb;
                t_enable;
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule